// File: doc/BRIEF.md
# Verb-Command I2C Target

This block is an I2C target that lets a host steer a codec-style device with 32-bit verb commands in place of plain address/data register writes. It watches the SCL and SDA lines through two-flop synchronizers in the system clock domain. SDA is driven open-drain: the block only ever pulls the line low, through `sda_oe`. The system clock must run at least eight times faster than SCL. There is no clock stretching and no 10-bit addressing.

A command is always four data bytes that follow the device address sent with the write bit. The 32-bit word splits into a 4-bit reserved field, an 8-bit node, a 12-bit verb and an 8-bit payload, most significant first.

If a stop follows the fourth byte, the command is a write. If a repeated start follows it instead, the command is a read: the host then re-addresses the target with the read bit set. The target then returns a 32-bit response word that the backend supplies on `resp_data`. In both cases the decoded fields are presented to the backend with a single-cycle strobe.

Top module: `verb_i2c_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal `DEV_ADDR` (default 7'h1C, so 8'h38 to write and 8'h39 to read). For any other address it leaves SDA released, ignores the rest of the transfer and raises no strobe.
- R2: After a matching write address, the target acknowledges each of the four command bytes by pulling SDA low during the ninth clock.
- R3: The fields map onto the four bytes as follows, and the reserved nibble reaches no output:
  - byte 1: reserved[3:0] in bits 7:4, node[7:4] in bits 3:0;
  - byte 2: node[3:0] in bits 7:4, verb[11:8] in bits 3:0;
  - byte 3: verb[7:0];
  - byte 4: payload[7:0].
- R4: A stop that follows the fourth acknowledged byte produces exactly one `cmd_valid` pulse of one clock, with `cmd_is_read` low and the decoded fields.
- R5: A repeated start that follows the fourth acknowledged byte produces one `cmd_valid` pulse with `cmd_is_read` high. The pulse comes before the read address phase.
- R6: `resp_data` is captured when the read address is acknowledged. Its value at later cycles has no effect on the transfer. The word is sent most significant byte first and most significant bit first. Sending continues while the host acknowledges, and a host NACK ends it.
- R7: `sda_oe` changes only while SCL is low.
- R8: A start or stop that arrives before all four command bytes are complete discards the partial command, and no strobe is raised.
- R9: A fifth data byte after a complete command is not acknowledged, and the command is dropped without a strobe.
- R10: A read address is acknowledged only directly after a repeated start that completed a four-byte command. Any other read address is NACKed.
- R11: While reset is held and after it is released, `sda_oe` and `cmd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_is_read | output | 1 | Command was closed by a repeated start |
| cmd_node | output | 8 | Node ID of the command |
| cmd_verb | output | 12 | Verb ID of the command |
| cmd_payload | output | 8 | Payload byte of the command |
| resp_data | input | 32 | Response word for the read phase |

## Verification
The bench builds the block with the default `DEV_ADDR` of 7'h1C, so real transfers use 8'h38 and 8'h39. Near-miss bytes such as 8'h3A exercise the address compare in R1, and a read address sent out of turn exercises R10. SCL runs at one twentieth of the system clock, which leaves room for the synchronizer latency before each SDA change. The stimulus vectors include all-ones and all-zero fields to show the byte-boundary splits of R3. They also change `resp_data` in the middle of a read to show the capture of R6.

// File: rtl/verb_i2c_target.sv
module verb_i2c_target #(
  parameter logic [6:0] DEV_ADDR = 7'h1C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic        cmd_valid,
  output logic        cmd_is_read,
  output logic [7:0]  cmd_node,
  output logic [11:0] cmd_verb,
  output logic [7:0]  cmd_payload,
  input  logic [31:0] resp_data
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDATA, S_WACK, S_HOLD, S_RDATA, S_RACK
  } st_t;

  st_t         st;
  logic [2:0]  scl_sy, sda_sy;
  logic        scl_s, scl_p, sda_s, sda_p;
  logic        start_det, stop_det, rise, fall;
  logic [3:0]  bitcnt;
  logic [7:0]  sh;
  logic [27:0] vbuf;
  logic [2:0]  nbytes;
  logic        rw, pend_rd, acked;
  logic [31:0] tx;
  logic        addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end
  end

  assign scl_s     = scl_sy[1];
  assign scl_p     = scl_sy[2];
  assign sda_s     = sda_sy[1];
  assign sda_p     = sda_sy[2];
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign rise      = scl_s & ~scl_p;
  assign fall      = ~scl_s & scl_p;
  assign addr_hit  = (sh[7:1] == DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      bitcnt      <= '0;
      sh          <= '0;
      vbuf        <= '0;
      nbytes      <= '0;
      rw          <= 1'b0;
      pend_rd     <= 1'b0;
      acked       <= 1'b0;
      tx          <= '0;
      sda_oe      <= 1'b0;
      cmd_valid   <= 1'b0;
      cmd_is_read <= 1'b0;
      cmd_node    <= '0;
      cmd_verb    <= '0;
      cmd_payload <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (start_det) begin
        if (st == S_HOLD) begin
          cmd_valid   <= 1'b1;
          cmd_is_read <= 1'b1;
          cmd_node    <= vbuf[27:20];
          cmd_verb    <= vbuf[19:8];
          cmd_payload <= vbuf[7:0];
          pend_rd     <= 1'b1;
        end else begin
          pend_rd <= 1'b0;
        end
        st     <= S_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        if (st == S_HOLD) begin
          cmd_valid   <= 1'b1;
          cmd_is_read <= 1'b0;
          cmd_node    <= vbuf[27:20];
          cmd_verb    <= vbuf[19:8];
          cmd_payload <= vbuf[7:0];
        end
        st      <= S_IDLE;
        pend_rd <= 1'b0;
        sda_oe  <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WDATA: begin
            if (rise) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (st == S_ADDR) begin
                if (addr_hit && (!sh[0] || pend_rd)) begin
                  rw     <= sh[0];
                  nbytes <= '0;
                  sda_oe <= 1'b1;
                  st     <= S_AACK;
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                vbuf   <= {vbuf[19:0], sh};
                nbytes <= nbytes + 3'd1;
                sda_oe <= 1'b1;
                st     <= S_WACK;
              end
            end
          end
          S_AACK: begin
            if (fall) begin
              pend_rd <= 1'b0;
              if (rw) begin
                tx     <= resp_data;
                sda_oe <= ~resp_data[31];
                bitcnt <= '0;
                st     <= S_RDATA;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_WDATA;
              end
            end
          end
          S_WACK: begin
            if (fall) begin
              sda_oe <= 1'b0;
              st     <= (nbytes == 3'd4) ? S_HOLD : S_WDATA;
            end
          end
          S_HOLD: begin
            if (fall) st <= S_IDLE;
          end
          S_RDATA: begin
            if (fall) begin
              tx <= {tx[30:0], 1'b0};
              if (bitcnt == 4'd7) begin
                bitcnt <= '0;
                sda_oe <= 1'b0;
                st     <= S_RACK;
              end else begin
                bitcnt <= bitcnt + 4'd1;
                sda_oe <= ~tx[30];
              end
            end
          end
          S_RACK: begin
            if (rise) begin
              acked <= ~sda_s;
            end else if (fall) begin
              if (acked) begin
                sda_oe <= ~tx[31];
                st     <= S_RDATA;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r4_write_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_is_read) |-> $past(stop_det));

  a_r5_read_after_rstart: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_is_read) |-> $past(start_det));

  a_r8_four_bytes_first: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(nbytes) == 3'd4));

  a_r7_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r2_drive_states: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st inside {S_AACK, S_WACK, S_RDATA}));

endmodule

// File: tb/verb_i2c_target_tb.sv
module verb_i2c_target_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        scl_h = 1'b1;
  logic        sda_h = 1'b1;
  logic        sda_oe, cmd_valid, cmd_is_read;
  logic [7:0]  cmd_node, cmd_payload;
  logic [11:0] cmd_verb;
  logic [31:0] resp_data;
  logic        sda_line;
  assign sda_line = sda_h & ~sda_oe;

  verb_i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line), .sda_oe(sda_oe),
    .cmd_valid(cmd_valid), .cmd_is_read(cmd_is_read), .cmd_node(cmd_node),
    .cmd_verb(cmd_verb), .cmd_payload(cmd_payload), .resp_data(resp_data)
  );

  int nchk = 0, nfail = 0, nstb = 0, wide = 0, bad_oe = 0;
  logic        cap_rd, vprev = 1'b0, oe_prev = 1'b0;
  logic [7:0]  cap_node, cap_pay;
  logic [11:0] cap_verb;
  bit          done = 1'b0;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (cmd_valid) begin
        nstb++;
        cap_rd = cmd_is_read; cap_node = cmd_node;
        cap_verb = cmd_verb; cap_pay = cmd_payload;
        if (vprev) wide++;
      end
      if ((sda_oe !== oe_prev) && scl_h) bad_oe++;
    end
    vprev   = cmd_valid;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  localparam int T = 5;
  task automatic tq; repeat (T) @(negedge clk); endtask
  task automatic i2c_start;  sda_h = 1; scl_h = 1; tq; sda_h = 0; tq; scl_h = 0; tq; endtask
  task automatic i2c_rstart; sda_h = 1; tq; scl_h = 1; tq; sda_h = 0; tq; scl_h = 0; tq; endtask
  task automatic i2c_stop;   sda_h = 0; tq; scl_h = 1; tq; sda_h = 1; tq; tq; endtask
  task automatic wbit(input logic b); sda_h = b; tq; scl_h = 1; tq; tq; scl_h = 0; tq; endtask
  task automatic rbit(output logic b); sda_h = 1; tq; scl_h = 1; tq; b = sda_line; tq; scl_h = 0; tq; endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic x;
    for (int k = 7; k >= 0; k--) wbit(d[k]);
    rbit(x);
    ack = ~x;
  endtask
  task automatic rbyte(output logic [7:0] d, input logic ack);
    logic x;
    for (int k = 7; k >= 0; k--) begin rbit(x); d[k] = x; end
    wbit(~ack);
  endtask

  // {read, reserved, node, verb, payload, response}
  localparam logic [64:0] VEC [6] = '{
    {1'b0, 4'h0, 8'h22, 12'h003, 8'hB0, 32'h0000_0000},
    {1'b1, 4'h0, 8'h22, 12'hF00, 8'h00, 32'h8001_7FFE},
    {1'b0, 4'hF, 8'hFF, 12'hFFF, 8'hFF, 32'h0000_0000},
    {1'b1, 4'hF, 8'h00, 12'h000, 8'h00, 32'hFFFF_FFFF},
    {1'b1, 4'h5, 8'hA5, 12'h5A3, 8'h3C, 32'h0000_0000},
    {1'b0, 4'hA, 8'h18, 12'h7E1, 8'h81, 32'h0000_0000}
  };

  initial begin
    logic [64:0] v;
    logic        rd, a0, a1, a2, a3, a4;
    logic [3:0]  rsv;
    logic [7:0]  node, pay, b0, b1, b2, b3;
    logic [11:0] verb;
    logic [31:0] rsp;
    int          n0;

    rst_n = 1'b0; resp_data = '0;
    repeat (4) @(negedge clk);
    chk(!sda_oe && !cmd_valid, "R11 in reset", {sda_oe, cmd_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sda_oe && !cmd_valid, "R11 after reset", {sda_oe, cmd_valid}, 0);

    for (int i = 0; i < 6; i++) begin
      v = VEC[i];
      rd = v[64]; rsv = v[63:60]; node = v[59:52]; verb = v[51:40]; pay = v[39:32]; rsp = v[31:0];
      resp_data = rsp; n0 = nstb;
      i2c_start;
      wbyte(8'h38, a0);
      wbyte({rsv, node[7:4]}, a1);
      wbyte({node[3:0], verb[11:8]}, a2);
      wbyte(verb[7:0], a3);
      wbyte(pay, a4);
      chk(a0 & a1 & a2 & a3 & a4, "R2 byte acks", {a0, a1, a2, a3, a4}, 5'h1F);
      if (rd) i2c_rstart; else i2c_stop;
      chk(nstb == n0 + 1, rd ? "R5 strobe count" : "R4 strobe count", nstb - n0, 1);
      chk(cap_rd == rd, "R4/R5 direction flag", cap_rd, rd);
      chk({cap_node, cap_verb, cap_pay} == {node, verb, pay}, "R3 fields",
          {cap_node, cap_verb, cap_pay}, {node, verb, pay});
      if (rd) begin
        wbyte(8'h39, a0);
        chk(a0, "R1 read address ack", a0, 1);
        rbyte(b0, 1'b1);
        resp_data = ~rsp;
        rbyte(b1, 1'b1);
        rbyte(b2, 1'b1);
        rbyte(b3, 1'b0);
        i2c_stop;
        chk({b0, b1, b2, b3} == rsp, "R6 response word", {b0, b1, b2, b3}, rsp);
        chk(nstb == n0 + 1, "R6 no extra strobe", nstb - n0, 1);
      end
    end

    n0 = nstb;
    i2c_start; wbyte(8'h3A, a0);
    chk(!a0, "R1 wrong address nack", a0, 0);
    wbyte(8'h02, a1); wbyte(8'h23, a2); wbyte(8'h00, a3); wbyte(8'h10, a4);
    i2c_stop;
    chk(!(a1 | a2 | a3 | a4), "R1 ignored after miss", {a1, a2, a3, a4}, 0);
    chk(nstb == n0, "R1 no strobe on miss", nstb - n0, 0);

    i2c_start; wbyte(8'h39, a0); i2c_stop;
    chk(!a0, "R10 read without verb", a0, 0);

    i2c_start; wbyte(8'h38, a0); wbyte(8'h01, a1); wbyte(8'h23, a2); i2c_stop;
    chk(nstb == n0, "R8 stop after two bytes", nstb - n0, 0);

    i2c_start; wbyte(8'h38, a0); wbyte(8'h01, a1); wbyte(8'h23, a2); wbyte(8'h45, a3);
    i2c_rstart; wbyte(8'h39, a4); i2c_stop;
    chk(nstb == n0, "R8 restart after three bytes", nstb - n0, 0);
    chk(!a4, "R10 read after short verb", a4, 0);

    i2c_start; wbyte(8'h38, a0); wbyte(8'h01, a1); wbyte(8'h23, a2); wbyte(8'h45, a3);
    wbyte(8'h67, a4); wbyte(8'h89, b0[0]);
    i2c_stop;
    chk(!b0[0], "R9 fifth byte nack", b0[0], 0);
    chk(nstb == n0, "R9 no strobe", nstb - n0, 0);

    i2c_start; wbyte(8'h38, a0); wbyte(8'h01, a1); wbyte(8'h23, a2); wbyte(8'h45, a3);
    wbyte(8'h67, a4); i2c_stop;
    chk(nstb == n0 + 1 && !cap_rd, "R4 recovery write", nstb - n0, 1);
    chk({cap_node, cap_verb, cap_pay} == {8'h12, 12'h345, 8'h67}, "R3 recovery fields",
        {cap_node, cap_verb, cap_pay}, {8'h12, 12'h345, 8'h67});

    chk(wide == 0, "R4 one-cycle strobe", wide, 0);
    chk(bad_oe == 0, "R7 drive while SCL low", bad_oe, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule